// File: doc/BRIEF.md
# DMA Bus Ownership Sequencer

This block gets bus ownership for one serial-port DMA request on a shared bus that a central arbiter controls. When the DMA request rises, the block raises a preemption request to the arbiter. It enables the local arbitration-vector logic while an arbitration cycle is running. After a lost cycle it keeps retrying. After a win it frames the data transfer with a burst signal until the request falls.

The sequencer has seven states. The encoding is chosen so that each state change flips exactly one bit of the state register. Two pass-through states keep this property on the transfer path. The arbitration-phase input comes from the arbiter's clock domain, so it passes through a two-flop synchronizer before the state logic uses it. Channel reset returns the machine to its idle state on the next clock edge.

Top module: `dma_bus_seq`

## Requirements
- R1: `rst_n` low clears everything asynchronously. `chan_reset` high at a clock edge forces state IDLE (000) at that edge. In IDLE all three control outputs are low.
- R2: In IDLE with `dma_req` high, the next state is REQ (001) and `bus_preempt` is high.
- R3: In REQ (001) or LOSE (111) with the synchronized arbitration phase high, the next state is ARB (011). In ARB, `arb_enable` and `bus_preempt` are both high.
- R4: In ARB with the synchronized phase low and `arb_won` low, the next state is LOSE (111). In LOSE, `arb_enable` is low and `bus_preempt` is high.
- R5: In ARB with the synchronized phase low and `arb_won` high, the next state is XFR1 (010) and `bus_preempt` is low. XFR1 always moves to XFR2 (110) on the next edge.
- R6: In XFR2, `burst` is high. XFR2 is held while `dma_req` is high and moves to XFR3 (100) when it is low. In XFR3, `burst` is low. XFR3 always moves to IDLE on the next edge.
- R7: Every state change not caused by a reset flips exactly one bit of `state_o`.
- R8: `arb_phase` acts through a two-flop synchronizer. A level applied before edge k changes the state at edge k+2 at the earliest. While the synchronized phase is low, REQ is held whatever `dma_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_reset | input | 1 | Synchronous channel reset to IDLE |
| dma_req | input | 1 | DMA service request from the serial port |
| arb_phase | input | 1 | Arbiter phase: high while arbitration runs, low in grant (asynchronous) |
| arb_won | input | 1 | Local vector-compare win, sampled when arbitration ends |
| bus_preempt | output | 1 | Bus request to the central arbiter |
| arb_enable | output | 1 | Lets the local arbitration vector compete |
| burst | output | 1 | Frames the DMA transfer |
| state_o | output | 3 | Current state code |

## Verification
A change on `dma_req`, `arb_won` or `chan_reset` shows up in the state and outputs at the next rising edge. A change on `arb_phase` shows up two edges later, because it first passes the synchronizer. The bench keeps its own model with the same delays, updated on the rising edge. It drives inputs and compares the outputs on the falling edge, so every comparison falls half a cycle after the edge that produced the value. The one-bit-change rule is checked against the code held on the previous edge, and only when no reset was applied at that edge.

// File: rtl/dma_bus_seq.sv
module dma_bus_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_reset,
  input  logic       dma_req,
  input  logic       arb_phase,
  input  logic       arb_won,
  output logic       bus_preempt,
  output logic       arb_enable,
  output logic       burst,
  output logic [2:0] state_o
);

  typedef enum logic [2:0] {
    S_IDLE = 3'b000,
    S_REQ  = 3'b001,
    S_ARB  = 3'b011,
    S_LOSE = 3'b111,
    S_XFR1 = 3'b010,
    S_XFR2 = 3'b110,
    S_XFR3 = 3'b100
  } st_t;

  st_t  st, st_nx;
  logic ph_s1, ph_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ph_s1, ph_s2} <= 2'b00;
    else        {ph_s1, ph_s2} <= {arb_phase, ph_s1};

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (dma_req) st_nx = S_REQ;
      S_REQ:  if (ph_s2) st_nx = S_ARB;
      S_ARB:  if (!ph_s2) st_nx = arb_won ? S_XFR1 : S_LOSE;
      S_LOSE: if (ph_s2) st_nx = S_ARB;
      S_XFR1: st_nx = S_XFR2;
      S_XFR2: if (!dma_req) st_nx = S_XFR3;
      S_XFR3: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          st <= S_IDLE;
    else if (chan_reset) st <= S_IDLE;
    else                 st <= st_nx;

  assign bus_preempt = (st == S_REQ) || (st == S_ARB) || (st == S_LOSE);
  assign arb_enable  = (st == S_ARB);
  assign burst       = (st == S_XFR2);
  assign state_o     = st;

  p_chan_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> (state_o == 3'b000) && !bus_preempt && !arb_enable && !burst);
  p_idle_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && dma_req && !chan_reset |=> (state_o == 3'b001) && bus_preempt);
  p_arb_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_REQ) || (st == S_LOSE)) && ph_s2 && !chan_reset
      |=> arb_enable && bus_preempt);
  p_lose_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARB) && !ph_s2 && !arb_won && !chan_reset
      |=> (state_o == 3'b111) && !arb_enable && bus_preempt);
  p_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARB) && !ph_s2 && arb_won && !chan_reset
      |=> (state_o == 3'b010) && !bus_preempt);
  p_xfr1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFR1) && !chan_reset |=> burst);
  p_xfr_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFR2) && !dma_req && !chan_reset |=> (state_o == 3'b100) && !burst);
  p_xfr3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFR3) |=> (state_o == 3'b000));
  p_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_reset |=> $countones(state_o ^ $past(state_o)) <= 1);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REQ) && !ph_s2 && !chan_reset |=> (state_o == 3'b001));

endmodule

// File: tb/dma_bus_seq_bench.sv
module dma_bus_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, chan_reset = 1'b0;
  logic dma_req = 1'b0, arb_phase = 1'b0, arb_won = 1'b0;
  logic bus_preempt, arb_enable, burst;
  logic [2:0] state_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dma_bus_seq u_dma_bus_seq (.clk, .rst_n, .chan_reset, .dma_req, .arb_phase,
    .arb_won, .bus_preempt, .arb_enable, .burst, .state_o);

  function automatic logic [2:0] f_next(logic [2:0] s, logic rq, logic ph, logic wn);
    case (s)
      3'b000: return rq ? 3'b001 : s;
      3'b001: return ph ? 3'b011 : s;
      3'b011: return ph ? s : (wn ? 3'b010 : 3'b111);
      3'b111: return ph ? 3'b011 : s;
      3'b010: return 3'b110;
      3'b110: return rq ? s : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string f_tag(logic [2:0] s);
    case (s)
      3'b000: return "R2";
      3'b001: return "R8";
      3'b011: return "R3";
      3'b111: return "R4";
      3'b010: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic m1 = 0, m2 = 0, mrst = 0;
  logic [2:0] ms = 0, prev_s = 0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m1 <= 0; m2 <= 0; ms <= 0; prev_s <= 0; mrst <= 1; end
    else begin
      m1 <= arb_phase; m2 <= m1;
      ms <= chan_reset ? 3'b000 : f_next(ms, dma_req, m2, arb_won);
      prev_s <= state_o; mrst <= chan_reset;
    end

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [5:0] e;
    string t;
    e = {ms, (ms == 3'b001) || (ms == 3'b011) || (ms == 3'b111), ms == 3'b011, ms == 3'b110};
    t = mrst ? "R1" : f_tag(ms);
    chk(t, {state_o, bus_preempt, arb_enable, burst}, e);
    if (!mrst) chk("R7", 6'(($countones(state_o ^ prev_s) <= 1)), 6'd1);
  endtask

  task automatic step(logic rq, logic ph, logic wn, logic cr);
    dma_req = rq; arb_phase = ph; arb_won = wn; chan_reset = cr;
    @(negedge clk);
    compare();
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    chk("R1", {state_o, bus_preempt, arb_enable, burst}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // directed: request, lose once, retry, win, transfer, finish
    step(1, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0);
    repeat (4) step(0, 1, 0, 0);
    repeat (4) step(0, 0, 0, 0);
    repeat (4) step(0, 1, 1, 0);
    repeat (4) step(1, 0, 1, 0);
    repeat (3) step(0, 0, 0, 0);
    // directed: channel reset during transfer
    step(1, 0, 0, 0);
    repeat (3) step(1, 1, 0, 0);
    repeat (4) step(1, 0, 1, 0);
    step(1, 0, 0, 1);
    step(0, 0, 0, 0);
    // random
    for (int i = 0; i < 4000; i++)
      step(($urandom % 8 == 0) ? ~dma_req : dma_req,
           ($urandom % 6 == 0) ? ~arb_phase : arb_phase,
           1'($urandom % 2), $urandom % 200 == 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule